// File: doc/BRIEF.md
# SECDED-protected memory with a fault-injection alias window

This block is a word-addressed memory that holds one data word and one check field per entry. It is reached through a simple request bus and appears at two address windows of equal size. A write through the normal window stores the data together with a freshly computed single-error-correct, double-error-detect (SECDED) check field. A write through the alias window replaces the data field only. The check field from the last normal write stays in place, so software can plant single-bit or double-bit faults with ordinary writes.

Reads through the normal window are checked and corrected. Reads through the alias window return the stored data word exactly as held, with no checking. Every response arrives one cycle after its read request. It carries a valid strobe and two per-response error flags that line up with the data.

A correctable error on a response sets a sticky flag, and an uncorrectable error sets a second sticky flag. Software reads both flags through a status word and clears them with a write-one-to-clear write to that word.

Top module: `ecc_alias_mem`

## Requirements
- R1: A write to the normal window (byte address 0x20000 to 0x23FFF, word index = (address − 0x20000) / 4) stores the data and new check bits. A later normal-window read of that word returns the data with both response error flags low.
- R2: A write to the alias window (0x24000 to 0x27FFF, same word index as offset − 0x24000) changes only the stored data. If it leaves exactly one bit different from the last normal write, a normal read returns the data of that normal write with `rsp_corrected` high.
- R3: If an alias write leaves exactly two bits different from the last normal write, a normal read raises `rsp_uncorr`, keeps `rsp_corrected` low and returns the stored data uncorrected.
- R4: A read through the alias window returns the stored data word as held, with both response error flags low.
- R5: `rsp_valid` is high for exactly one cycle, in the cycle after each read request, and at no other time. Writes never produce a response, and the error flags are low whenever `rsp_valid` is low.
- R6: `evt_flags[0]` goes high in the cycle after a response with `rsp_corrected` high. It stays high until it is cleared.
- R7: `evt_flags[1]` goes high in the cycle after a response with `rsp_uncorr` high. It stays high until it is cleared.
- R8: A write to the status word (byte address 0x28000) clears `evt_flags[0]` when `wdata[0]` is 1 and clears `evt_flags[1]` when `wdata[1]` is 1. Zero bits leave a flag unchanged. A flag that is being set in the same cycle as its clear stays set.
- R9: A read of the status word returns the sticky flags in `rsp_data[1:0]` (bit 0 correctable, bit 1 uncorrectable), with the upper bits zero.
- R10: Writes to any other address change no stored word and no flag. Reads of any other address give a response with data zero and both error flags low.
- R11: After reset, `rsp_valid` is low and `evt_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (18) | Byte address; bits below the word size are ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W (32) | Read data (corrected, raw or status) |
| rsp_corrected | output | 1 | This response held a corrected single-bit error |
| rsp_uncorr | output | 1 | This response held an uncorrectable error |
| evt_flags | output | 2 | Sticky error flags: bit 0 correctable, bit 1 uncorrectable |

## Verification
The assertions check the response protocol on every cycle. They cover the one-cycle read response, the absence of responses after writes or idle cycles, and the mutual exclusion of the two error flags. They also cover the rules for the sticky flags: set one cycle after an error response, held until a matching clear bit, cleared by that bit unless an error arrives in the same cycle, and never raised without a cause. Only the bench's scenarios can show that the data itself is right: correction after single-bit alias faults in the low and high bit, detection of double faults, raw alias read-back, repair by a fresh normal write, isolation of addresses outside the windows, and the status read-back.

// File: rtl/ecc_alias_pkg.sv
package ecc_alias_pkg;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_NORM  = 2'd1,
      WIN_ALIAS = 2'd2,
      WIN_STAT  = 2'd3
   } win_e;

   // number of Hamming bits needed to cover a data word of width dw
   function automatic int ham_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // codeword position (1-based, powers of two reserved for check bits) of data bit j
   function automatic int data_pos(input int j);
      int k;
      int pos;
      k   = 0;
      pos = 0;
      for (int p = 3; p < 4096; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (k == j) pos = p;
            k++;
         end
      end
      return pos;
   endfunction

endpackage

// File: rtl/ecm_win_dec.sv
module ecm_win_dec
   import ecc_alias_pkg::*;
#(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned NORM_BASE  = 32'h2_0000,
   parameter int unsigned ALIAS_BASE = 32'h2_4000,
   parameter int unsigned WIN_BYTES  = 32'h4000,
   parameter int unsigned STAT_ADDR  = 32'h2_8000,
   parameter int unsigned BYTE_SHIFT = 2,
   parameter int unsigned IDX_W      = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output win_e              win_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam logic [ADDR_W:0]   N_LO  = (ADDR_W+1)'(NORM_BASE);
   localparam logic [ADDR_W:0]   N_HI  = (ADDR_W+1)'(NORM_BASE + WIN_BYTES);
   localparam logic [ADDR_W:0]   A_LO  = (ADDR_W+1)'(ALIAS_BASE);
   localparam logic [ADDR_W:0]   A_HI  = (ADDR_W+1)'(ALIAS_BASE + WIN_BYTES);
   localparam logic [ADDR_W-1:0] S_ADR = ADDR_W'(STAT_ADDR);

   logic [ADDR_W:0] a_ext;
   logic            in_norm;
   logic            in_alias;
   logic            is_stat;

   assign a_ext    = {1'b0, addr_i};
   assign in_norm  = (a_ext >= N_LO) && (a_ext < N_HI);
   assign in_alias = (a_ext >= A_LO) && (a_ext < A_HI);
   assign is_stat  = (addr_i[ADDR_W-1:BYTE_SHIFT] == S_ADR[ADDR_W-1:BYTE_SHIFT]);

   always_comb begin
      win_o = WIN_NONE;
      idx_o = '0;
      if (in_norm) begin
         win_o = WIN_NORM;
         idx_o = IDX_W'((a_ext - N_LO) >> BYTE_SHIFT);
      end else if (in_alias) begin
         win_o = WIN_ALIAS;
         idx_o = IDX_W'((a_ext - A_LO) >> BYTE_SHIFT);
      end else if (is_stat) begin
         win_o = WIN_STAT;
      end
   end
endmodule

// File: rtl/ecm_secded_enc.sv
module ecm_secded_enc
   import ecc_alias_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned HAM_W = ham_bits(DATA_W),
   localparam int unsigned CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);
   logic [HAM_W-1:0] ham;

   for (genvar r = 0; r < HAM_W; r++) begin : g_ham
      logic [DATA_W-1:0] sel;
      for (genvar j = 0; j < DATA_W; j++) begin : g_sel
         localparam int POS = data_pos(j);
         if (((POS >> r) & 1) == 1) begin : g_on
            assign sel[j] = data_i[j];
         end else begin : g_off
            assign sel[j] = 1'b0;
         end
      end
      assign ham[r] = ^sel;
   end

   // overall parity bit makes the whole codeword even
   assign chk_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/ecm_secded_dec.sv
module ecm_secded_dec
   import ecc_alias_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned HAM_W = ham_bits(DATA_W),
   localparam int unsigned CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   output logic [DATA_W-1:0] data_o,
   output logic              single_o,
   output logic              double_o
);
   localparam int MAX_POS = data_pos(DATA_W - 1);

   logic [CHK_W-1:0] calc;
   logic [CHK_W-1:0] diff;
   logic [HAM_W-1:0] syn;
   logic             par_odd;
   logic             syn_nz;
   logic             syn_big;

   ecm_secded_enc #(.DATA_W(DATA_W)) i_enc (
      .data_i (data_i),
      .chk_o  (calc)
   );

   assign diff    = chk_i ^ calc;
   assign syn     = diff[HAM_W-1:0];
   assign par_odd = ^diff;
   assign syn_nz  = (syn != '0);
   assign syn_big = (syn > HAM_W'(MAX_POS));

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int POS = data_pos(j);
      assign data_o[j] = data_i[j] ^ (par_odd && (syn == HAM_W'(POS)));
   end

   assign single_o = par_odd && !syn_big;
   assign double_o = (!par_odd && syn_nz) || (par_odd && syn_big);
endmodule

// File: rtl/ecm_store.sv
module ecm_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CHK_W  = 7,
   parameter int unsigned DEPTH  = 4096,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              we_data_i,
   input  logic              we_chk_i,
   input  logic              re_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CHK_W-1:0]  wchk_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [CHK_W-1:0]  rchk_o
);
   logic [DATA_W-1:0] data_mem [DEPTH];
   logic [CHK_W-1:0]  chk_mem  [DEPTH];

   always_ff @(posedge clk) begin
      if (we_data_i) data_mem[idx_i] <= wdata_i;
      if (we_chk_i)  chk_mem[idx_i]  <= wchk_i;
      if (re_i) begin
         rdata_o <= data_mem[idx_i];
         rchk_o  <= chk_mem[idx_i];
      end
   end
endmodule

// File: rtl/ecc_alias_mem.sv
module ecc_alias_mem
   import ecc_alias_pkg::*;
#(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NORM_BASE  = 32'h2_0000,
   parameter int unsigned ALIAS_BASE = 32'h2_4000,
   parameter int unsigned WIN_BYTES  = 32'h4000,
   parameter int unsigned STAT_ADDR  = 32'h2_8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_corrected,
   output logic              rsp_uncorr,
   output logic [1:0]        evt_flags
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned BYTE_SHIFT = $clog2(WORD_BYTES);
   localparam int unsigned DEPTH      = WIN_BYTES / WORD_BYTES;
   localparam int unsigned IDX_W      = $clog2(DEPTH);
   localparam int unsigned HAM_W      = ham_bits(DATA_W);
   localparam int unsigned CHK_W      = HAM_W + 1;

   // elaboration-time parameter checks
   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be a whole number of bytes");
   end
   if ((WIN_BYTES % WORD_BYTES) != 0 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_win
      $error("WIN_BYTES must hold a power-of-two number of words");
   end
   if ((ALIAS_BASE < NORM_BASE + WIN_BYTES) && (ALIAS_BASE + WIN_BYTES > NORM_BASE)) begin : g_overlap
      $error("normal and alias windows overlap");
   end
   if ((STAT_ADDR >= NORM_BASE && STAT_ADDR < NORM_BASE + WIN_BYTES) ||
       (STAT_ADDR >= ALIAS_BASE && STAT_ADDR < ALIAS_BASE + WIN_BYTES)) begin : g_stat_clash
      $error("status word lies inside a memory window");
   end
   if (ALIAS_BASE + WIN_BYTES > (64'd1 << ADDR_W)) begin : g_addr_small
      $error("ADDR_W too narrow for the alias window");
   end

   win_e             win;
   logic [IDX_W-1:0] idx;
   logic             rd_req;
   logic             wr_req;
   logic             mem_hit;
   logic [CHK_W-1:0] wchk;
   logic [DATA_W-1:0] raw_data;
   logic [CHK_W-1:0]  raw_chk;
   logic [DATA_W-1:0] fix_data;
   logic              dec_single;
   logic              dec_double;

   win_e             rsp_win_q;
   logic             rsp_valid_q;
   logic [1:0]       stat_snap_q;
   logic [1:0]       flags_q;
   logic [1:0]       clr_bits;
   logic [1:0]       set_bits;

   ecm_win_dec #(
      .ADDR_W     (ADDR_W),
      .NORM_BASE  (NORM_BASE),
      .ALIAS_BASE (ALIAS_BASE),
      .WIN_BYTES  (WIN_BYTES),
      .STAT_ADDR  (STAT_ADDR),
      .BYTE_SHIFT (BYTE_SHIFT),
      .IDX_W      (IDX_W)
   ) i_win_dec (
      .addr_i (bus_addr),
      .win_o  (win),
      .idx_o  (idx)
   );

   assign rd_req  = bus_req && !bus_we;
   assign wr_req  = bus_req &&  bus_we;
   assign mem_hit = (win == WIN_NORM) || (win == WIN_ALIAS);

   ecm_secded_enc #(.DATA_W(DATA_W)) i_enc (
      .data_i (bus_wdata),
      .chk_o  (wchk)
   );

   ecm_store #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .DEPTH  (DEPTH)
   ) i_store (
      .clk       (clk),
      .idx_i     (idx),
      .we_data_i (wr_req && mem_hit),
      .we_chk_i  (wr_req && (win == WIN_NORM)),
      .re_i      (rd_req && mem_hit),
      .wdata_i   (bus_wdata),
      .wchk_i    (wchk),
      .rdata_o   (raw_data),
      .rchk_o    (raw_chk)
   );

   ecm_secded_dec #(.DATA_W(DATA_W)) i_dec (
      .data_i   (raw_data),
      .chk_i    (raw_chk),
      .data_o   (fix_data),
      .single_o (dec_single),
      .double_o (dec_double)
   );

   // response pipeline stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_win_q   <= WIN_NONE;
         stat_snap_q <= 2'b00;
      end else begin
         rsp_valid_q <= rd_req;
         if (rd_req) begin
            rsp_win_q   <= win;
            stat_snap_q <= flags_q;
         end
      end
   end

   always_comb begin
      rsp_data = '0;
      unique case (rsp_win_q)
         WIN_NORM:  rsp_data = dec_double ? raw_data : fix_data;
         WIN_ALIAS: rsp_data = raw_data;
         WIN_STAT:  rsp_data = {{(DATA_W-2){1'b0}}, stat_snap_q};
         default:   rsp_data = '0;
      endcase
   end

   assign rsp_valid     = rsp_valid_q;
   assign rsp_corrected = rsp_valid_q && (rsp_win_q == WIN_NORM) && dec_single;
   assign rsp_uncorr    = rsp_valid_q && (rsp_win_q == WIN_NORM) && dec_double;

   // sticky flags: set wins over a clear in the same cycle
   assign clr_bits = (wr_req && (win == WIN_STAT)) ? bus_wdata[1:0] : 2'b00;
   assign set_bits = {rsp_uncorr, rsp_corrected};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= 2'b00;
      else        flags_q <= (flags_q & ~clr_bits) | set_bits;
   end

   assign evt_flags = flags_q;
endmodule

// File: rtl/ecc_alias_mem_chk.sv
module ecc_alias_mem_chk #(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STAT_ADDR = 32'h2_8000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rsp_valid,
   input logic              rsp_corrected,
   input logic              rsp_uncorr,
   input logic [1:0]        evt_flags
);
   localparam int unsigned BS = $clog2(DATA_W / 8);
   localparam logic [ADDR_W-1:0] S_ADR = ADDR_W'(STAT_ADDR);

   logic clr_hit;
   assign clr_hit = bus_req && bus_we && (bus_addr[ADDR_W-1:BS] == S_ADR[ADDR_W-1:BS]);

   a_r5_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> rsp_valid);
   a_r5_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !rsp_valid);
   a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_corrected && !rsp_uncorr));
   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_corrected && rsp_uncorr));
   a_r6_single_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_corrected |=> evt_flags[0]);
   a_r7_double_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncorr |=> evt_flags[1]);
   a_r6_single_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flags[0] && !(clr_hit && bus_wdata[0])) |=> evt_flags[0]);
   a_r7_double_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flags[1] && !(clr_hit && bus_wdata[1])) |=> evt_flags[1]);
   a_r8_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && bus_wdata[0] && !rsp_corrected) |=> !evt_flags[0]);
   a_r8_clear_double: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && bus_wdata[1] && !rsp_uncorr) |=> !evt_flags[1]);
   a_r6_no_cause_single: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_flags[0] && !rsp_corrected) |=> !evt_flags[0]);
   a_r7_no_cause_double: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_flags[1] && !rsp_uncorr) |=> !evt_flags[1]);
endmodule

bind ecc_alias_mem ecc_alias_mem_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .STAT_ADDR (STAT_ADDR)
) i_ecc_alias_mem_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_req       (bus_req),
   .bus_we        (bus_we),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .rsp_valid     (rsp_valid),
   .rsp_corrected (rsp_corrected),
   .rsp_uncorr    (rsp_uncorr),
   .evt_flags     (evt_flags)
);

// File: tb/test_ecc_alias_mem.sv
module test_ecc_alias_mem;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [17:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_corrected;
   logic        rsp_uncorr;
   logic [1:0]  evt_flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   ecc_alias_mem i_ecc_alias_mem (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_req       (bus_req),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_data      (rsp_data),
      .rsp_corrected (rsp_corrected),
      .rsp_uncorr    (rsp_uncorr),
      .evt_flags     (evt_flags)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- reference model ----------------
   logic [31:0] m_gold [int];
   logic [31:0] m_raw  [int];
   logic        exp_valid = 1'b0;
   logic [31:0] exp_data = '0;
   logic        exp_corr = 1'b0;
   logic        exp_unc = 1'b0;
   logic [1:0]  exp_flags = 2'b00;
   string       exp_tag = "R5";

   // 0 none, 1 normal, 2 alias, 3 status
   function automatic int region(input logic [17:0] a);
      if (a >= 18'h20000 && a < 18'h24000) return 1;
      if (a >= 18'h24000 && a < 18'h28000) return 2;
      if (a[17:2] == 16'(18'h28000 >> 2)) return 3;
      return 0;
   endfunction

   function automatic int word_of(input logic [17:0] a);
      if (region(a) == 1) return (int'(a) - 32'h20000) / 4;
      return (int'(a) - 32'h24000) / 4;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_valid = 1'b0; exp_corr = 1'b0; exp_unc = 1'b0; exp_flags = 2'b00;
      end else begin
         logic [1:0] nf;
         int rg;
         int w;
         int d;
         nf = exp_flags;
         rg = region(bus_addr);
         if (bus_req && bus_we && rg == 3) nf = nf & ~bus_wdata[1:0];
         if (exp_valid && exp_corr) nf[0] = 1'b1;
         if (exp_valid && exp_unc)  nf[1] = 1'b1;
         exp_valid = bus_req && !bus_we;
         exp_corr = 1'b0; exp_unc = 1'b0; exp_data = '0; exp_tag = "R10";
         if (bus_req) begin
            if (rg == 1 || rg == 2) w = word_of(bus_addr);
            else w = 0;
            if (bus_we) begin
               if (rg == 1) begin m_gold[w] = bus_wdata; m_raw[w] = bus_wdata; end
               if (rg == 2) m_raw[w] = bus_wdata;
            end else begin
               if (rg == 1) begin
                  d = $countones(m_gold[w] ^ m_raw[w]);
                  if (d == 0) begin exp_data = m_raw[w]; exp_tag = "R1"; end
                  else if (d == 1) begin exp_data = m_gold[w]; exp_corr = 1'b1; exp_tag = "R2"; end
                  else begin exp_data = m_raw[w]; exp_unc = 1'b1; exp_tag = "R3"; end
               end else if (rg == 2) begin
                  exp_data = m_raw[w]; exp_tag = "R4";
               end else if (rg == 3) begin
                  exp_data = {30'd0, exp_flags}; exp_tag = "R9";
               end
            end
         end
         exp_flags = nf;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rsp_valid === exp_valid, "R5 valid", 32'(rsp_valid), 32'(exp_valid));
         if (exp_valid) begin
            check(rsp_data === exp_data, exp_tag, rsp_data, exp_data);
            check(rsp_corrected === exp_corr, "R2 corrected flag", 32'(rsp_corrected), 32'(exp_corr));
            check(rsp_uncorr === exp_unc, "R3 uncorrectable flag", 32'(rsp_uncorr), 32'(exp_unc));
         end else begin
            check(!rsp_corrected && !rsp_uncorr, "R5 flags idle", {30'd0, rsp_uncorr, rsp_corrected}, 32'd0);
         end
         check(evt_flags === exp_flags, "R6/R7/R8 sticky", 32'(evt_flags), 32'(exp_flags));
      end
   end

   // ---------------- stimulus ----------------
   task automatic op(input bit we, input logic [17:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_req = 1'b0; bus_we = 1'b0;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(rsp_valid === 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      check(evt_flags === 2'b00, "R11 flags in reset", 32'(evt_flags), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // R1: normal writes and reads, window edges included
      op(1, 18'h20000, 32'h1234_5678);
      op(1, 18'h23FFC, 32'hCAFE_F00D);
      op(1, 18'h20100, 32'h0000_0000);
      op(1, 18'h20104, 32'hFFFF_FFFF);
      op(0, 18'h20000, '0);
      op(0, 18'h23FFC, '0);
      op(0, 18'h20100, '0);
      op(0, 18'h20104, '0);
      idle(2);

      // R2, R4: single-bit faults via the alias window
      op(1, 18'h24000, 32'h1234_5678 ^ 32'h0000_0001);
      op(0, 18'h20000, '0);
      op(0, 18'h24000, '0);
      op(1, 18'h27FFC, 32'hCAFE_F00D ^ 32'h8000_0000);
      op(0, 18'h23FFC, '0);
      idle(4);
      check(evt_flags === 2'b01, "R6 single sticky held", 32'(evt_flags), 32'd1);

      // R3: double-bit fault
      op(1, 18'h24100, 32'h0000_0180);
      op(0, 18'h20100, '0);
      op(0, 18'h24100, '0);
      idle(2);
      check(evt_flags === 2'b11, "R7 double sticky", 32'(evt_flags), 32'd3);

      // R9: status read-back
      op(0, 18'h28000, '0);
      idle(1);

      // R8: write-one-to-clear, one bit at a time
      op(1, 18'h28000, 32'h0000_0001);
      idle(2);
      check(evt_flags === 2'b10, "R8 clear bit0 only", 32'(evt_flags), 32'd2);
      op(1, 18'h28000, 32'h0000_0002);
      idle(2);
      check(evt_flags === 2'b00, "R8 clear bit1", 32'(evt_flags), 32'd0);

      // R8: set beats clear in the same cycle
      op(0, 18'h20000, '0);
      op(1, 18'h28000, 32'h0000_0003);
      idle(2);
      check(evt_flags === 2'b01, "R8 set wins over clear", 32'(evt_flags), 32'd1);
      op(0, 18'h28000, '0);
      op(1, 18'h28000, 32'h0000_0003);
      idle(2);

      // R1: a fresh normal write repairs; same-data alias write stays clean
      op(1, 18'h20000, 32'h1234_5678);
      op(0, 18'h20000, '0);
      op(1, 18'h24104, 32'hFFFF_FFFF);
      op(0, 18'h20104, '0);
      idle(2);

      // R10: addresses outside the windows
      op(1, 18'h1FFFC, 32'h5555_AAAA);
      op(1, 18'h28004, 32'h0000_0003);
      op(1, 18'h3FFFC, 32'h0F0F_0F0F);
      op(0, 18'h1FFFC, '0);
      op(0, 18'h3FFFC, '0);
      op(0, 18'h20000, '0);
      op(0, 18'h23FFC, '0);
      idle(3);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule